// File: doc/BRIEF.md
# Systolic IIR Filter Array

This block filters a stream of signed fixed-point samples with a recursive filter of order one or two: y(n) = a1·y(n-1) + a2·y(n-2) + b0·x(n) + b1·x(n-1). The a2 term applies only when the `ORDER` parameter is 2. Each of the coefficients b0, b1, a1 and (for order two) a2 sits in its own processing element (PE) and never leaves it. The PEs form a linear chain.

The current sample reaches the first PE from the input port. It then moves one PE to the right through a single register. The two fed-back outputs feed the recursive PEs from the output registers. Partial sums ripple from the rightmost PE back to the leftmost through adders only, with no register between them. The total is rounded and saturated once at the output. The array therefore accepts one sample on every clock, and every PE does a useful multiply-add in every accepted cycle.

The input valid works as a clock enable for the whole sample path. Coefficients load through a small write port: a select code plus a data word.

Top module: `iir_systolic`

## Requirements
- R1: With `ORDER`=1 the output is y(n) = a1·y(n-1) + b0·x(n) + b1·x(n-1), where x(n-1) and y(n-1) are the previous accepted sample and the previous output.
- R2: With `ORDER`=2 the output adds a2·y(n-2) to the R1 sum.
- R3: Number formats and rounding:
  - Samples are signed Q1.15 and coefficients are signed Q2.14.
  - All products are summed at full precision.
  - The sum is rounded once: 2^13 is added, then the result is shifted arithmetically right by 14 bits.
- R4: A rounded result above 32767 gives 32767. A rounded result below -32768 gives -32768. The saturated value is also the value that is fed back.
- R5: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high, and low otherwise.
- R6: While `in_valid` is low, `out_data` and all sample history hold. Idle gaps inside a stream do not change any later output.
- R7: A synchronous reset clears `out_data`, `out_valid` and all sample and feedback history to zero. Coefficients keep the values written before the reset.
- R8: A write with `coef_we` high stores `coef_data` into the PE named by `coef_sel`: 0 = b0, 1 = b1, 2 = a1, 3 = a2. A write in the same cycle as an accepted sample does not affect that sample. It applies from the next accepted sample on.
- R9: With `ORDER`=1, a write with `coef_sel`=3 has no effect on any output.
- R10: Samples accepted on consecutive cycles each produce an output on the following cycle, one per clock, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample accept strobe; also the array clock enable |
| in_data | input | 16 | Input sample, signed Q1.15 |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 2 | Coefficient select: 0 = b0, 1 = b1, 2 = a1, 3 = a2 |
| coef_data | input | 16 | Coefficient value, signed Q2.14 |
| out_valid | output | 1 | Output strobe, one cycle after each accepted sample |
| out_data | output | 16 | Filtered sample, signed Q1.15 |

## Verification
The bench targets these corner cases:
- **Rounding ties.** Products land exactly on half an output LSB, for both signs. A design that truncated, or rounded half away from zero, would be off by one LSB on the negative cases.
- **Saturation.** Full-scale inputs are pushed through large coefficients. A design that wrapped instead of clamping, or that fed back the unclamped sum, would flip sign and then drift on the following outputs.
- **Coefficient write timing.** A write lands in the same cycle as an accepted sample. A design that wrote through to the multiplier would change that sample's result.
- **Idle gaps and reset.** Gaps are inserted mid-stream and a reset is applied mid-stream. Histories that advanced during idle cycles, or coefficients lost at reset, would corrupt every later output.

// File: rtl/iir_sys_pkg.sv
package iir_sys_pkg;
  localparam int SAMPLE_W = 16;
  localparam int COEF_W   = 16;
  localparam int SEL_W    = 2;

  typedef enum logic [SEL_W-1:0] {
    TAP_B0 = 2'd0,
    TAP_B1 = 2'd1,
    TAP_A1 = 2'd2,
    TAP_A2 = 2'd3
  } tap_e;
endpackage

// File: rtl/iir_pe.sv
// One processing element: a stationary coefficient, a multiplier and an adder
// on the leftward partial-sum path (no register on that path).
module iir_pe #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int AW = 34
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic signed [CW-1:0] wr_data,
  input  logic signed [DW-1:0] operand,
  input  logic signed [AW-1:0] sum_in,
  output logic signed [AW-1:0] sum_out
);
  localparam int PW = DW + CW;

  logic signed [CW-1:0] coef_q;
  logic signed [PW-1:0] prod;

  always_ff @(posedge clk) begin
    if (wr_en) coef_q <= wr_data;
  end

  assign prod    = coef_q * operand;
  assign sum_out = sum_in + AW'(prod);
endmodule

// File: rtl/iir_round_sat.sv
// Round half up at the fraction boundary, then clamp to the sample range.
module iir_round_sat #(
  parameter int AW   = 34,
  parameter int DW   = 16,
  parameter int FRAC = 14
) (
  input  logic signed [AW-1:0] acc,
  output logic signed [DW-1:0] y
);
  localparam logic signed [AW-1:0] HALF = AW'(1) << (FRAC - 1);
  localparam logic signed [AW-1:0] YMAX = AW'(2 ** (DW - 1) - 1);
  localparam logic signed [AW-1:0] YMIN = -YMAX - AW'(1);

  logic signed [AW-1:0] biased;
  logic signed [AW-1:0] shifted;

  always_comb begin
    biased  = acc + HALF;
    shifted = biased >>> FRAC;
    if (shifted > YMAX)      y = YMAX[DW-1:0];
    else if (shifted < YMIN) y = YMIN[DW-1:0];
    else                     y = shifted[DW-1:0];
  end
endmodule

// File: rtl/iir_systolic.sv
module iir_systolic
  import iir_sys_pkg::*;
#(
  parameter int ORDER = 2,
  parameter int DW    = SAMPLE_W,
  parameter int CW    = COEF_W,
  parameter int FRAC  = COEF_W - 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic                 coef_we,
  input  logic [SEL_W-1:0]     coef_sel,
  input  logic signed [CW-1:0] coef_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int NPE = ORDER + 2;
  localparam int AW  = DW + CW + $clog2(NPE);

  logic signed [DW-1:0] x_d1;
  logic signed [DW-1:0] y_q;
  logic signed [DW-1:0] y_d2;
  logic signed [DW-1:0] y_next;
  logic signed [DW-1:0] opnd [NPE];
  logic signed [AW-1:0] psum [NPE+1];

  assign psum[NPE] = '0;

  genvar j;
  generate
    for (j = 0; j < NPE; j++) begin : g_pe
      if (j == int'(TAP_B0)) begin : g_op
        assign opnd[j] = in_data;
      end else if (j == int'(TAP_B1)) begin : g_op
        assign opnd[j] = x_d1;
      end else if (j == int'(TAP_A1)) begin : g_op
        assign opnd[j] = y_q;
      end else begin : g_op
        assign opnd[j] = y_d2;
      end

      iir_pe #(.DW(DW), .CW(CW), .AW(AW)) u_pe (
        .clk    (clk),
        .wr_en  (coef_we && (coef_sel == SEL_W'(j))),
        .wr_data(coef_data),
        .operand(opnd[j]),
        .sum_in (psum[j+1]),
        .sum_out(psum[j])
      );
    end

    if (ORDER == 2) begin : g_hist2
      always_ff @(posedge clk) begin
        if (rst)           y_d2 <= '0;
        else if (in_valid) y_d2 <= y_q;
      end
    end else begin : g_hist1
      assign y_d2 = '0;
    end
  endgenerate

  iir_round_sat #(.AW(AW), .DW(DW), .FRAC(FRAC)) u_rnd (
    .acc(psum[0]),
    .y  (y_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_d1      <= '0;
      y_q       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        x_d1 <= in_data;
        y_q  <= y_next;
      end
    end
  end

  assign out_data = y_q;
endmodule

// File: rtl/iir_systolic_chk.sv
module iir_systolic_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          out_valid,
  input logic [DW-1:0] out_data
);
  // R5: an accepted sample yields an output strobe on the next cycle
  p_valid_after_accept_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R5: no output strobe without a sample in the cycle before
  p_no_spurious_valid_r5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R6: the output word holds across idle cycles
  p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  // R7: reset clears the output word and the strobe
  p_reset_clears_r7: assert property (@(posedge clk)
    rst |=> (out_data == '0 && !out_valid));
endmodule

bind iir_systolic iir_systolic_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_data (out_data)
);

// File: tb/iir_systolic_test.sv
`timescale 1ns/1ps
module iir_systolic_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic coef_we = 1'b0;
  logic [1:0] coef_sel = '0;
  logic signed [15:0] coef_data = '0;
  logic ov2, ov1;
  logic signed [15:0] od2, od1;

  always #5 clk = ~clk;

  iir_systolic #(.ORDER(2)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .coef_we(coef_we), .coef_sel(coef_sel), .coef_data(coef_data),
    .out_valid(ov2), .out_data(od2));

  iir_systolic #(.ORDER(1)) uut_o1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .coef_we(coef_we), .coef_sel(coef_sel), .coef_data(coef_data),
    .out_valid(ov1), .out_data(od1));

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  string tag = "R7";

  // reference state, index 0 = second order, 1 = first order
  int coef [2][4];
  int xd [2];
  int yp2 [2];
  int ed [2];
  bit ev [2];

  function automatic int ref_filt(int ord, int x, int x1, int y1, int y2,
                                  int b0, int b1, int a1, int a2);
    longint acc;
    acc = longint'(b0) * x + longint'(b1) * x1 + longint'(a1) * y1;
    if (ord == 2) acc += longint'(a2) * y2;
    acc = (acc + 8192) >>> 14;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  task automatic compare(int k, logic v, logic signed [15:0] d);
    vectors++;
    if (v !== ev[k] || d !== 16'(ed[k])) begin
      fails++;
      $display("FAIL %s order%0d: valid=%0b data=%0d expected valid=%0b data=%0d",
               tag, 2 - k, v, d, ev[k], ed[k]);
    end
  endtask

  task automatic cyc(bit r, bit v, int d, bit we, int sel, int cd);
    @(negedge clk);
    rst = r; in_valid = v; in_data = 16'(d);
    coef_we = we; coef_sel = 2'(sel); coef_data = 16'(cd);
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      if (r) begin
        ev[k] = 1'b0; ed[k] = 0; xd[k] = 0; yp2[k] = 0;
      end else begin
        ev[k] = v;
        if (v) begin
          int ny;
          ny = ref_filt(2 - k, d, xd[k], ed[k], yp2[k],
                        coef[k][0], coef[k][1], coef[k][2], coef[k][3]);
          yp2[k] = ed[k]; ed[k] = ny; xd[k] = d;
        end
      end
      if (we && !(k == 1 && sel == 3)) coef[k][sel] = cd;
    end
    #1;
    compare(0, ov2, od2);
    compare(1, ov1, od1);
  endtask

  task automatic load(int b0, int b1, int a1, int a2);
    cyc(0, 0, 0, 1, 0, b0);
    cyc(0, 0, 0, 1, 1, b1);
    cyc(0, 0, 0, 1, 2, a1);
    cyc(0, 0, 0, 1, 3, a2);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      xd[k] = 0; yp2[k] = 0; ed[k] = 0; ev[k] = 0;
      for (int c = 0; c < 4; c++) coef[k][c] = 0;
    end
    // R7: reset state (R9: a2 write ignored by the first-order array)
    tag = "R7";
    repeat (3) cyc(1, 0, 0, 0, 0, 0);
    tag = "R8 R9";
    load(8192, 4096, 8192, -4096);
    // R1 R2 R10: impulse response on back-to-back samples
    tag = "R1 R2 R10";
    cyc(0, 1, 16384, 0, 0, 0);
    repeat (8) cyc(0, 1, 0, 0, 0, 0);
    // R6: gaps inside a stream
    tag = "R6 R5";
    cyc(0, 1, -12000, 0, 0, 0);
    repeat (3) cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 1, 7000, 0, 0, 0);
    cyc(0, 0, 5, 1, 3, 2000);
    cyc(0, 1, 300, 0, 0, 0);
    // R8: write in the same cycle as an accepted sample
    tag = "R8";
    cyc(0, 1, 10000, 1, 0, -16384);
    cyc(0, 1, 10000, 0, 0, 0);
    cyc(0, 1, -5000, 1, 2, 3000);
    cyc(0, 1, 0, 0, 0, 0);
    // R3: rounding ties of both signs
    tag = "R3";
    load(8192, 0, 0, 0);
    cyc(0, 1, 1, 0, 0, 0);
    cyc(0, 1, -1, 0, 0, 0);
    cyc(0, 1, 3, 0, 0, 0);
    cyc(0, 1, -3, 0, 0, 0);
    cyc(0, 1, 32767, 0, 0, 0);
    // R4: saturation both ways, saturated value fed back
    tag = "R4";
    load(32767, 32767, 16384, -8192);
    cyc(0, 1, 32767, 0, 0, 0);
    cyc(0, 1, 32767, 0, 0, 0);
    cyc(0, 1, -32768, 0, 0, 0);
    cyc(0, 1, -32768, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    // R3 R1 R2: mixed stream with random gaps
    tag = "R3 R1 R2";
    load(6000, -3000, 9000, -5000);
    for (int n = 0; n < 80; n++)
      cyc(0, ($urandom % 4) != 0, int'($urandom % 65536) - 32768, 0, 0, 0);
    // R7: mid-stream reset keeps coefficients
    tag = "R7";
    cyc(1, 1, 1234, 0, 0, 0);
    cyc(0, 1, 16384, 0, 0, 0);
    repeat (5) cyc(0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule